// File: doc/BRIEF.md
# Protected Flash Erase/Program Controller

This block sits between a microcontroller's special-function-register write bus and a behavioural model of a 64KB on-chip flash array. Three byte-wide registers steer it. A command register accepts key bytes that start erasures. A page register selects one of 128 pages of 512 bytes. A control register holds a program enable, a mass-erase enable and an access-pulse selection. An erase starts only after the matching setup is in place and the correct key byte is written. A whole-array erase also needs the debug port to be enabled.

Ordinary data-store cycles from the processor are routed by the program enable. When it is clear, they go to the RAM port. When it is set, they program the flash. Programming can only clear bits. An erased byte reads 0xFF. Each erase or program holds a busy flag for a fixed, parameterised number of cycles. The new contents become visible in the same cycle the flag falls. While the flag is high, further commands and flash stores are dropped.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Setting control bit 1 (mass-erase enable) at register offset 0x42 and then writing 0xAA to the command register at offset 0x40 while `dbg_en` is high erases every byte of the array to 0xFF.
- R2: A 0xAA command write while `dbg_en` is low, or while the mass-erase enable is clear, starts nothing: `busy` stays low and flash contents are unchanged.
- R3: Writing a value to the page register at offset 0x41 selects page number = value bits [7:1]. A following 0x55 command write sets all 512 bytes of that page, addresses page*512 to page*512+511, to 0xFF. Bytes outside the page keep their values.
- R4: A command write of any value other than 0x55 or 0xAA starts no erase and leaves the flash unchanged.
- R5: After reset, every flash byte reads 0xFF, `busy` is 0, `ram_we` is 0 and `acc_lowpwr` is 1.
- R6: With control bit 0 (program enable) clear, a store cycle appears in the same cycle on `ram_we`/`ram_addr`/`ram_wdata` and leaves the flash unchanged.
- R7: With control bit 0 set, a store cycle programs the flash byte at `st_addr` and does not raise `ram_we`.
- R8: Programming stores the bitwise AND of the old byte and the new data, so no bit returns from 0 to 1 without an erase.
- R9: `busy` is high for exactly PAGE_CYCLES, MASS_CYCLES or PROG_CYCLES cycles after the launching edge. The new contents are readable from the cycle in which `busy` is low again.
- R10: While `busy` is high, command writes and program-enabled store cycles are ignored, and such stores do not reach the RAM port. Page and control registers stay writable; an erase already running uses the page latched at its launch.
- R11: The mass-erase enable clears itself when a mass erase completes or when a 0xAA write is rejected. A control write in the cycle of completion takes precedence over the self-clear.
- R12: When a valid erase command and a program-enabled store arrive in the same idle cycle, the erase starts and the store is dropped.
- R13: `acc_lowpwr` follows control bit 2 (1 = low-power access pulse) from the cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register offset |
| sfr_wdata | input | 8 | Register write data |
| dbg_en | input | 1 | Debug port enabled; qualifies mass erase |
| st_valid | input | 1 | Processor data-store cycle |
| st_addr | input | ADDR_W | Store address |
| st_wdata | input | 8 | Store data |
| ram_we | output | 1 | Store routed to RAM |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| fl_raddr | input | ADDR_W | Flash read address |
| fl_rdata | output | 8 | Flash read data (combinational) |
| busy | output | 1 | Erase or program in progress |
| acc_lowpwr | output | 1 | Low-power access-pulse selection |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a valid page-erase key and a program-enabled store. The bench drives both in one clock. Afterwards, the stored address must still read 0xFF and a byte in the selected page must be erased.

The second pair is the completion edge of a mass erase and a control write that sets the mass-erase enable again. The bench counts clocks from the launch so that the write lands on the final busy cycle. It then judges the outcome at the ports: a second 0xAA write must raise `busy`, which shows that the software write won over the self-clear.

// File: rtl/fctl_pkg.sv
// Shared definitions for the protected flash controller: operation codes,
// erase keys and control-register bit positions.
package fctl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PAGE = 2'd1,
        OP_MASS = 2'd2,
        OP_PROG = 2'd3
    } fop_e;

    localparam logic [7:0] KEY_PAGE = 8'h55;
    localparam logic [7:0] KEY_MASS = 8'hAA;

    localparam int CB_PWE = 0;   // program enable
    localparam int CB_MEE = 1;   // mass-erase enable
    localparam int CB_LPW = 2;   // low-power access pulse

endpackage

// File: rtl/fctl_sfr_regs.sv
// Register decoder: holds page number and control bits and checks key bytes.
// Assumes one register write per cycle. Launch requests are combinational
// and already qualified by the busy flag.
module fctl_sfr_regs
    import fctl_pkg::*;
#(
    parameter logic [7:0] A_CMD  = 8'h40,
    parameter logic [7:0] A_PAGE = 8'h41,
    parameter logic [7:0] A_CTRL = 8'h42,
    parameter int         PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              busy,
    input  logic              dbg_en,
    input  logic              mass_done,
    output logic [PAGE_W-1:0] page_num,
    output logic              pwe,
    output logic              mee,
    output logic              lowpwr,
    output logic              req_page,
    output logic              req_mass
);

    logic cmd_wr, mass_key, mass_rej, ctrl_wr, page_wr;

    // Decode writes and qualify key bytes.
    always_comb begin
        cmd_wr   = sfr_wr && (sfr_addr == A_CMD) && !busy;
        ctrl_wr  = sfr_wr && (sfr_addr == A_CTRL);
        page_wr  = sfr_wr && (sfr_addr == A_PAGE);
        req_page = cmd_wr && (sfr_wdata == KEY_PAGE);
        mass_key = cmd_wr && (sfr_wdata == KEY_MASS);
        req_mass = mass_key && mee && dbg_en;
        mass_rej = mass_key && !(mee && dbg_en);
    end

    // Hold the page number and control bits; a write beats the enable self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_num <= '0;
            pwe      <= 1'b0;
            mee      <= 1'b0;
            lowpwr   <= 1'b1;
        end else begin
            if (page_wr)
                page_num <= sfr_wdata[7 -: PAGE_W];
            if (ctrl_wr) begin
                pwe    <= sfr_wdata[CB_PWE];
                mee    <= sfr_wdata[CB_MEE];
                lowpwr <= sfr_wdata[CB_LPW];
            end else if (mass_done || mass_rej) begin
                mee <= 1'b0;
            end
        end
    end

    // R2: a rejected mass key leaves the enable clear unless rewritten.
    p_reject_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mass_rej && !ctrl_wr) |=> !mee);

endmodule

// File: rtl/fctl_sequencer.sv
// Operation sequencer: accepts one launch at a time, latches its operands,
// holds busy for the operation's cycle count and pulses commit on the last cycle.
// Assumes every cycle count is at least 2.
module fctl_sequencer
    import fctl_pkg::*;
#(
    parameter int PAGE_CYCLES = 24,
    parameter int MASS_CYCLES = 48,
    parameter int PROG_CYCLES = 4,
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_page,
    input  logic              launch_mass,
    input  logic              launch_prog,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              busy,
    output fop_e              op,
    output logic              commit,
    output logic [PAGE_W-1:0] c_page,
    output logic [ADDR_W-1:0] c_addr,
    output logic [7:0]        c_data
);

    localparam int M1    = (PAGE_CYCLES > MASS_CYCLES) ? PAGE_CYCLES : MASS_CYCLES;
    localparam int MAXC  = (M1 > PROG_CYCLES) ? M1 : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Last busy cycle is the commit cycle.
    always_comb commit = busy && (cnt_q == CNT_W'(1));

    // Launch, count down, and retire operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            op     <= OP_IDLE;
            cnt_q  <= '0;
            c_page <= '0;
            c_addr <= '0;
            c_data <= '0;
        end else if (!busy) begin
            if (launch_page) begin
                busy   <= 1'b1;
                op     <= OP_PAGE;
                cnt_q  <= CNT_W'(PAGE_CYCLES);
                c_page <= page_in;
            end else if (launch_mass) begin
                busy   <= 1'b1;
                op     <= OP_MASS;
                cnt_q  <= CNT_W'(MASS_CYCLES);
            end else if (launch_prog) begin
                busy   <= 1'b1;
                op     <= OP_PROG;
                cnt_q  <= CNT_W'(PROG_CYCLES);
                c_addr <= addr_in;
                c_data <= data_in;
            end
        end else if (commit) begin
            busy  <= 1'b0;
            op    <= OP_IDLE;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R12: the top never offers two launches at once.
    p_one_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch_page, launch_mass, launch_prog}));

endmodule

// File: rtl/fctl_flash_array.sv
// Behavioural flash array built from wide words, each with a valid bit.
// A clear valid bit means the word is erased and reads all ones, so a mass
// erase clears the valid vector in one cycle. Programming ANDs one byte into
// its word. Reads are combinational.
module fctl_flash_array
    import fctl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 32,
    parameter int PAGE_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  fop_e              op,
    input  logic [PAGE_W-1:0] c_page,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [7:0]        c_data,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int WORDS  = 1 << IDX_W;
    localparam int WPP_W  = IDX_W - PAGE_W;
    localparam int WPP    = 1 << WPP_W;
    localparam int WORD_W = WORD_BYTES * 8;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  vld_q;

    logic [IDX_W-1:0]  r_idx, w_idx;
    logic [OFF_W-1:0]  r_off, w_off;
    logic [WORD_W-1:0] r_word, w_base, w_new;

    // Read path: erased words read as all ones.
    always_comb begin
        r_idx  = raddr[ADDR_W-1:OFF_W];
        r_off  = raddr[OFF_W-1:0];
        r_word = vld_q[r_idx] ? mem[r_idx] : '1;
        rdata  = r_word[{r_off, 3'b000} +: 8];
    end

    // Program path: AND the new byte into the current word.
    always_comb begin
        w_idx  = c_addr[ADDR_W-1:OFF_W];
        w_off  = c_addr[OFF_W-1:0];
        w_base = vld_q[w_idx] ? mem[w_idx] : '1;
        w_new  = w_base;
        w_new[{w_off, 3'b000} +: 8] = w_base[{w_off, 3'b000} +: 8] & c_data;
    end

    // Store the programmed word.
    always_ff @(posedge clk) begin
        if (commit && (op == OP_PROG))
            mem[w_idx] <= w_new;
    end

    // Track which words hold data; erasing clears their valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (commit) begin
            case (op)
                OP_PROG: vld_q[w_idx] <= 1'b1;
                OP_MASS: vld_q <= '0;
                OP_PAGE: for (int j = 0; j < WPP; j++)
                             vld_q[{c_page, WPP_W'(j)}] <= 1'b0;
                default: ;
            endcase
        end
    end

    // R9: a commit always carries a real operation.
    p_commit_has_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (op != OP_IDLE));

endmodule

// File: rtl/flash_erase_ctrl.sv
// Top of the protected flash controller. It ties the register decoder, the
// sequencer and the array model together and routes data-store cycles to the
// RAM port or to flash programming. Erase keys take priority over a store.
module flash_erase_ctrl
    import fctl_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter int         WORD_BYTES  = 32,
    parameter int         PAGE_CYCLES = 24,
    parameter int         MASS_CYCLES = 48,
    parameter int         PROG_CYCLES = 4,
    parameter logic [7:0] A_CMD       = 8'h40,
    parameter logic [7:0] A_PAGE      = 8'h41,
    parameter logic [7:0] A_CTRL      = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              dbg_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [7:0]        st_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [ADDR_W-1:0] fl_raddr,
    output logic [7:0]        fl_rdata,
    output logic              busy,
    output logic              acc_lowpwr
);

    localparam int PAGE_W = 7;

    logic [PAGE_W-1:0] page_num, c_page;
    logic [ADDR_W-1:0] c_addr;
    logic [7:0]        c_data;
    logic              pwe, mee, req_page, req_mass, launch_prog, commit, mass_done;
    fop_e              cur_op;

    always_comb mass_done = commit && (cur_op == OP_MASS);

    fctl_sfr_regs #(
        .A_CMD(A_CMD), .A_PAGE(A_PAGE), .A_CTRL(A_CTRL), .PAGE_W(PAGE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .busy(busy), .dbg_en(dbg_en), .mass_done(mass_done),
        .page_num(page_num), .pwe(pwe), .mee(mee), .lowpwr(acc_lowpwr),
        .req_page(req_page), .req_mass(req_mass)
    );

    // Route stores: RAM when program enable is clear; flash when idle and no erase key.
    always_comb begin
        ram_we      = st_valid && !pwe;
        ram_addr    = st_addr;
        ram_wdata   = st_wdata;
        launch_prog = st_valid && pwe && !busy && !req_page && !req_mass;
    end

    fctl_sequencer #(
        .PAGE_CYCLES(PAGE_CYCLES), .MASS_CYCLES(MASS_CYCLES),
        .PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch_page(req_page), .launch_mass(req_mass),
        .launch_prog(launch_prog), .page_in(page_num), .addr_in(st_addr),
        .data_in(st_wdata), .busy(busy), .op(cur_op), .commit(commit),
        .c_page(c_page), .c_addr(c_addr), .c_data(c_data)
    );

    fctl_flash_array #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .PAGE_W(PAGE_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(cur_op), .c_page(c_page),
        .c_addr(c_addr), .c_data(c_data), .raddr(fl_raddr), .rdata(fl_rdata)
    );

    // R2: a mass erase only ever starts with the debug port enabled.
    p_mass_dbg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && (cur_op == OP_MASS)) |-> $past(dbg_en));

    // R4: erases start only from a command-register write of a key byte.
    p_key_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && (cur_op == OP_PAGE || cur_op == OP_MASS)) |->
        $past(sfr_wr && sfr_addr == A_CMD &&
              (sfr_wdata == KEY_PAGE || sfr_wdata == KEY_MASS)));

    // R6: one store never reaches both RAM and flash.
    p_store_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && launch_prog));

    // R10: a running operation is neither replaced nor cut short.
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> (busy && $stable(cur_op)));

    // R11: completion clears the mass-erase enable unless a control write lands.
    p_mee_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mass_done && !(sfr_wr && sfr_addr == A_CTRL)) |=> !mee);

endmodule

// File: tb/sim_flash_erase_ctrl.sv
module sim_flash_erase_ctrl;

    localparam int PC = 12;
    localparam int MC = 20;
    localparam int GC = 3;

    localparam logic [1:0] K_SFR = 2'd0, K_ST = 2'd1, K_WAIT = 2'd2, K_RD = 2'd3;

    typedef struct packed {
        logic [1:0]  k;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [NV] = '{
        '{K_RD,   16'h0000, 8'h00, 8'hFF, 4'd5},
        '{K_SFR,  16'h0042, 8'h05, 8'h00, 4'd7},
        '{K_ST,   16'h1234, 8'h3C, 8'h00, 4'd7},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd7},
        '{K_RD,   16'h1234, 8'h00, 8'h3C, 4'd7},
        '{K_ST,   16'h1234, 8'hF0, 8'h00, 4'd8},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd8},
        '{K_RD,   16'h1234, 8'h00, 8'h30, 4'd8},
        '{K_ST,   16'h1235, 8'hA5, 8'h00, 4'd7},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd7},
        '{K_RD,   16'h1235, 8'h00, 8'hA5, 4'd7},
        '{K_ST,   16'h03FF, 8'h11, 8'h00, 4'd7},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd7},
        '{K_ST,   16'h0400, 8'h22, 8'h00, 4'd7},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd7},
        '{K_ST,   16'h0200, 8'h33, 8'h00, 4'd7},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd7},
        '{K_SFR,  16'h0041, 8'h12, 8'h00, 4'd3},
        '{K_SFR,  16'h0040, 8'h54, 8'h00, 4'd4},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd4},
        '{K_RD,   16'h1234, 8'h00, 8'h30, 4'd4},
        '{K_SFR,  16'h0040, 8'h00, 8'h00, 4'd4},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd4},
        '{K_RD,   16'h1235, 8'h00, 8'hA5, 4'd4},
        '{K_SFR,  16'h0040, 8'h55, 8'h00, 4'd3},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd3},
        '{K_RD,   16'h1234, 8'h00, 8'hFF, 4'd3},
        '{K_RD,   16'h1235, 8'h00, 8'hFF, 4'd3},
        '{K_RD,   16'h0200, 8'h00, 8'h33, 4'd3},
        '{K_SFR,  16'h0041, 8'h02, 8'h00, 4'd3},
        '{K_SFR,  16'h0040, 8'h55, 8'h00, 4'd3},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd3},
        '{K_RD,   16'h03FF, 8'h00, 8'hFF, 4'd3},
        '{K_RD,   16'h0200, 8'h00, 8'hFF, 4'd3},
        '{K_RD,   16'h0400, 8'h00, 8'h22, 4'd3},
        '{K_SFR,  16'h0040, 8'hAA, 8'h00, 4'd2},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd2},
        '{K_RD,   16'h0400, 8'h00, 8'h22, 4'd2},
        '{K_SFR,  16'h0042, 8'h04, 8'h00, 4'd6},
        '{K_ST,   16'h0500, 8'h00, 8'h00, 4'd6},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd6},
        '{K_RD,   16'h0500, 8'h00, 8'hFF, 4'd6},
        '{K_ST,   16'h0400, 8'h00, 8'h00, 4'd6},
        '{K_WAIT, 16'h0000, 8'h00, 8'h00, 4'd6},
        '{K_RD,   16'h0400, 8'h00, 8'h22, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        dbg_en = 1'b0;
    logic        st_valid = 1'b0;
    logic [15:0] st_addr = '0;
    logic [7:0]  st_wdata = '0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [15:0] fl_raddr = '0;
    logic [7:0]  fl_rdata;
    logic        busy;
    logic        acc_lowpwr;

    int nvec = 0;
    int nfail = 0;

    flash_erase_ctrl #(
        .PAGE_CYCLES(PC), .MASS_CYCLES(MC), .PROG_CYCLES(GC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .dbg_en(dbg_en), .st_valid(st_valid),
        .st_addr(st_addr), .st_wdata(st_wdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .fl_raddr(fl_raddr),
        .fl_rdata(fl_rdata), .busy(busy), .acc_lowpwr(acc_lowpwr)
    );

    always #4 clk = ~clk;

    function automatic string rname(input logic [3:0] c);
        case (c)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic sfr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic st(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_wdata = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        fl_raddr = a;
        #1;
        chk(tag, {8'h00, fl_rdata}, {8'h00, e});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nvec++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        chk("R5", {15'd0, busy}, 16'd0);
        chk("R5", {15'd0, acc_lowpwr}, 16'd1);
        chk("R5", {15'd0, ram_we}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].k)
                K_SFR:  sfr(TBL[i].a[7:0], TBL[i].d);
                K_ST:   st(TBL[i].a, TBL[i].d);
                K_WAIT: wait_idle();
                default: rd(TBL[i].a, TBL[i].e, rname(TBL[i].r));
            endcase
        end

        // R6: store passes to RAM port in the same cycle
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'h0777; st_wdata = 8'h5A;
        #1;
        chk("R6", {15'd0, ram_we}, 16'd1);
        chk("R6", ram_addr, 16'h0777);
        chk("R6", {8'h00, ram_wdata}, 16'h005A);
        @(negedge clk);
        st_valid = 1'b0;

        // R13: low-power pulse selection follows control bit 2
        sfr(8'h42, 8'h00);
        chk("R13", {15'd0, acc_lowpwr}, 16'd0);
        sfr(8'h42, 8'h04);
        chk("R13", {15'd0, acc_lowpwr}, 16'd1);

        // R2 / R11: mass key without debug port is rejected and clears the enable
        sfr(8'h42, 8'h06);
        dbg_en = 1'b0;
        sfr(8'h40, 8'hAA);
        chk("R2", {15'd0, busy}, 16'd0);
        dbg_en = 1'b1;
        sfr(8'h40, 8'hAA);
        chk("R11", {15'd0, busy}, 16'd0);

        // R1 / R9: mass erase duration and effect
        sfr(8'h42, 8'h06);
        sfr(8'h40, 8'hAA);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R9", 16'(n), 16'(MC));
        rd(16'h0400, 8'hFF, "R1");
        rd(16'h1235, 8'hFF, "R1");
        sfr(8'h40, 8'hAA);
        chk("R11", {15'd0, busy}, 16'd0);

        // R10: commands and flash stores dropped while busy
        sfr(8'h42, 8'h05);
        st(16'h0610, 8'h0F);
        wait_idle();
        sfr(8'h41, 8'h12);
        sfr(8'h40, 8'h55);
        chk("R10", {15'd0, busy}, 16'd1);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 16'h0600; st_wdata = 8'h00;
        #1;
        chk("R10", {15'd0, ram_we}, 16'd0);
        @(negedge clk);
        st_valid = 1'b0;
        sfr(8'h41, 8'h06);
        sfr(8'h40, 8'h55);
        wait_idle();
        rd(16'h0600, 8'hFF, "R10");
        rd(16'h0610, 8'h0F, "R10");

        // R12: erase key and flash store in the same cycle
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = 8'h40; sfr_wdata = 8'h55;
        st_valid = 1'b1; st_addr = 16'h0700; st_wdata = 8'hAB;
        @(negedge clk);
        sfr_wr = 1'b0; st_valid = 1'b0;
        wait_idle();
        rd(16'h0700, 8'hFF, "R12");
        rd(16'h0610, 8'hFF, "R12");

        // R11: control write on the completion edge wins over self-clear
        sfr(8'h42, 8'h06);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = 8'h40; sfr_wdata = 8'hAA;
        @(negedge clk);
        sfr_wr = 1'b0;
        repeat (MC - 1) @(negedge clk);
        chk("R11", {15'd0, busy}, 16'd1);
        sfr_wr = 1'b1; sfr_addr = 8'h42; sfr_wdata = 8'h06;
        @(negedge clk);
        sfr_wr = 1'b0;
        chk("R9", {15'd0, busy}, 16'd0);
        sfr(8'h40, 8'hAA);
        chk("R11", {15'd0, busy}, 16'd1);
        wait_idle();

        finish_run();
    end

endmodule